// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a four-bit binary-coded decimal digit into the seven segment drive levels of a numeric display. A code register sits in front of the decoder. While the capture control is low, the register follows the incoming digit and the decoder sees the live input. While the control is high, the register keeps the last captured digit and the input pins have no effect.

Two active-low overrides act on the segment outputs after the decoder. The lamp-test input lights every segment and takes priority over everything else. The blanking input darkens every segment and ranks below lamp test. Neither override touches the stored digit, so releasing an override brings the held digit back at once.

Codes above nine are not digits and produce a dark display. The glyphs for six and nine have no tail by default; a parameter selects tailed glyphs instead. The segment outputs are registered, so every change on the inputs reaches the outputs one clock later.

Top module: `bcd_seg_latch_decoder`

## Requirements
- R1: Input `bcd_in` is an 8421-weighted code with bit 3 as the most significant bit. The segment vector has segment a at bit 0 through segment g at bit 6, and a 1 lights a segment. With both overrides released, digits 0 to 9 produce 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F and 67 (hex), in that order.
- R2: With the default parameter setting, digit 6 is drawn without segment a (7C) and digit 9 is drawn without segment d (67).
- R3: Any effective code from 10 to 15 drives all seven segments to 0, even when both overrides are released.
- R4: While `lamp_test_n` is 0, the outputs are 7F, whatever the values of `blank_n`, `capture_n` and `bcd_in`.
- R5: While `lamp_test_n` is 1 and `blank_n` is 0, the outputs are 00, whatever the values of `capture_n` and `bcd_in`.
- R6: On a clock edge with `capture_n` at 0, the code register loads `bcd_in`, and the decoder sees `bcd_in` directly. While `capture_n` is 1, the register keeps its value, the decoder sees the stored code, and changes on `bcd_in` have no effect on the outputs.
- R7: Asserting lamp test or blanking does not change the stored code. After the override is released, the outputs show the held digit again.
- R8: The outputs are registered. A change on any input appears on `seg` after the next rising clock edge and not before it.
- R9: A synchronous active-high `rst` clears the stored code to 0 and drives `seg` to 00. After reset, with `capture_n` at 1 and both overrides released, the display shows digit 0 (3F).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lamp_test_n | input | 1 | Lights all segments when low; highest priority |
| blank_n | input | 1 | Darkens all segments when low |
| capture_n | input | 1 | Low: the code register follows the input. High: the register holds its code |
| bcd_in | input | 4 | BCD digit, bit 3 most significant |
| seg | output | 7 | Segment drive levels, a at bit 0 through g at bit 6, active high |

## Verification
On every cycle, the assertions check the override priority (lamp test lights all segments, blanking darkens them), the dark output for live codes above nine, the reset result, and the code register, which must load on a capture cycle and stay unchanged on a hold cycle. Three behaviours need the bench's scenarios: the exact glyph of each digit, including the tailless six and nine; a held digit that survives later changes on the data pins and reappears after an override is released; and the single cycle of output latency.

// File: rtl/seg7_pkg.sv
`timescale 1ns/1ps
package seg7_pkg;
   localparam int SEG_N = 7;
   typedef logic [SEG_N-1:0] seg_t;
   localparam seg_t SEG_DARK = '0;
   localparam seg_t SEG_LIT  = '1;
endpackage

// File: rtl/code_hold.sv
`timescale 1ns/1ps
module code_hold #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_eff,
   output logic [CODE_W-1:0] code_held
);
   always_ff @(posedge clk) begin
      if (rst)
         code_held <= '0;
      else if (!capture_n)
         code_held <= code_in;
   end

   // transparent while capturing, stored value while holding
   assign code_eff = capture_n ? code_held : code_in;
endmodule

// File: rtl/digit_glyph.sv
`timescale 1ns/1ps
module digit_glyph
   import seg7_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter bit TAILED = 1'b0
) (
   input  logic [CODE_W-1:0] code,
   output seg_t              glyph
);
   seg_t glyph_six;
   seg_t glyph_nine;

   generate
      if (TAILED) begin : g_tailed
         assign glyph_six  = 7'h7D;
         assign glyph_nine = 7'h6F;
      end else begin : g_tailless
         assign glyph_six  = 7'h7C;
         assign glyph_nine = 7'h67;
      end
   endgenerate

   always_comb begin
      case (code)
         CODE_W'(0): glyph = 7'h3F;
         CODE_W'(1): glyph = 7'h06;
         CODE_W'(2): glyph = 7'h5B;
         CODE_W'(3): glyph = 7'h4F;
         CODE_W'(4): glyph = 7'h66;
         CODE_W'(5): glyph = 7'h6D;
         CODE_W'(6): glyph = glyph_six;
         CODE_W'(7): glyph = 7'h07;
         CODE_W'(8): glyph = 7'h7F;
         CODE_W'(9): glyph = glyph_nine;
         default:    glyph = SEG_DARK;
      endcase
   end
endmodule

// File: rtl/seg_drive.sv
`timescale 1ns/1ps
module seg_drive
   import seg7_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic lamp_test_n,
   input  logic blank_n,
   input  seg_t glyph,
   output seg_t seg
);
   seg_t seg_next;

   always_comb begin
      if (!lamp_test_n)
         seg_next = SEG_LIT;
      else if (!blank_n)
         seg_next = SEG_DARK;
      else
         seg_next = glyph;
   end

   always_ff @(posedge clk) begin
      if (rst)
         seg <= SEG_DARK;
      else
         seg <= seg_next;
   end
endmodule

// File: rtl/bcd_seg_latch_decoder.sv
`timescale 1ns/1ps
module bcd_seg_latch_decoder
   import seg7_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter bit TAILED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lamp_test_n,
   input  logic              blank_n,
   input  logic              capture_n,
   input  logic [CODE_W-1:0] bcd_in,
   output logic [SEG_N-1:0]  seg
);
   generate
      if (CODE_W != 4) begin : g_bad_code_w
         $error("bcd_seg_latch_decoder: CODE_W must be 4");
      end
      if (SEG_N != 7) begin : g_bad_seg_n
         $error("bcd_seg_latch_decoder: SEG_N must be 7");
      end
   endgenerate

   logic [CODE_W-1:0] code_eff;
   logic [CODE_W-1:0] code_held;
   seg_t              glyph;

   code_hold #(.CODE_W(CODE_W)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .capture_n (capture_n),
      .code_in   (bcd_in),
      .code_eff  (code_eff),
      .code_held (code_held)
   );

   digit_glyph #(.CODE_W(CODE_W), .TAILED(TAILED)) u_glyph (
      .code  (code_eff),
      .glyph (glyph)
   );

   seg_drive u_drive (
      .clk         (clk),
      .rst         (rst),
      .lamp_test_n (lamp_test_n),
      .blank_n     (blank_n),
      .glyph       (glyph),
      .seg         (seg)
   );
endmodule

// File: rtl/bcd_seg_checker.sv
`timescale 1ns/1ps
module bcd_seg_checker #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              lamp_test_n,
   input logic              blank_n,
   input logic              capture_n,
   input logic [CODE_W-1:0] bcd_in,
   input logic [CODE_W-1:0] code_held,
   input logic [6:0]        seg
);
   assert_lamp_test_R4: assert property (@(posedge clk) disable iff (rst)
      !lamp_test_n |=> seg == 7'h7F);

   assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
      (lamp_test_n && !blank_n) |=> seg == 7'h00);

   assert_illegal_dark_R3: assert property (@(posedge clk) disable iff (rst)
      (lamp_test_n && blank_n && !capture_n && bcd_in > CODE_W'(9)) |=> seg == 7'h00);

   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
      capture_n |=> $stable(code_held));

   assert_capture_load_R6: assert property (@(posedge clk) disable iff (rst)
      !capture_n |=> code_held == $past(bcd_in));

   // reset result, checked on the edge after a reset cycle
   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (seg == 7'h00 && code_held == '0));
endmodule

bind bcd_seg_latch_decoder bcd_seg_checker #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .lamp_test_n (lamp_test_n),
   .blank_n     (blank_n),
   .capture_n   (capture_n),
   .bcd_in      (bcd_in),
   .code_held   (code_held),
   .seg         (seg)
);

// File: tb/bcd_seg_latch_decoder_tb.sv
`timescale 1ns/1ps
module bcd_seg_latch_decoder_tb;
   localparam logic [6:0] GLYPH [16] = '{
      7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7C, 7'h07,
      7'h7F, 7'h67, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};

   logic       clk = 1'b0;
   logic       rst;
   logic       lamp_test_n;
   logic       blank_n;
   logic       capture_n;
   logic [3:0] bcd_in;
   logic [6:0] seg;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;
   logic [3:0] held_m;

   always #4 clk = ~clk;

   bcd_seg_latch_decoder u_dut (
      .clk(clk), .rst(rst), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
      .capture_n(capture_n), .bcd_in(bcd_in), .seg(seg)
   );

   task automatic check(input string req, input logic [6:0] exp);
      total++;
      if (seg !== exp) begin
         bad++;
         $display("FAIL %s seg=%h expected=%h", req, seg, exp);
      end
   endtask

   // drive at the falling edge, sample 1 ns after the next rising edge
   task automatic step(input logic r, input logic lt, input logic bi,
                       input logic cap, input logic [3:0] d);
      @(negedge clk);
      rst = r; lamp_test_n = lt; blank_n = bi; capture_n = cap; bcd_in = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      rst = 1'b1; lamp_test_n = 1'b1; blank_n = 1'b1; capture_n = 1'b0; bcd_in = 4'd0;
      step(1'b1, 1'b0, 1'b1, 1'b0, 4'd8);
      step(1'b1, 1'b0, 1'b1, 1'b0, 4'd8);
      check("R9 reset output", 7'h00);
      held_m = 4'd0;

      // walk every code under every control combination
      for (int c = 0; c < 16; c++) begin
         for (int k = 0; k < 8; k++) begin
            logic lt, bi, cap;
            logic [3:0] eff;
            logic [6:0] exp;
            string tag;
            lt = k[0]; bi = k[1]; cap = k[2];
            eff = cap ? held_m : 4'(c);
            if (!lt)           begin exp = 7'h7F; tag = "R4 lamp test"; end
            else if (!bi)      begin exp = 7'h00; tag = "R5 blank"; end
            else if (eff > 9)  begin exp = 7'h00; tag = "R3 illegal code"; end
            else               begin exp = GLYPH[eff]; tag = "R1 digit glyph"; end
            step(1'b0, lt, bi, cap, 4'(c));
            if (!cap) held_m = 4'(c);
            check(tag, exp);
         end
      end

      // tailless six and nine
      step(1'b0, 1'b1, 1'b1, 1'b0, 4'd6);
      check("R2 six without a", 7'h7C);
      step(1'b0, 1'b1, 1'b1, 1'b0, 4'd9);
      check("R2 nine without d", 7'h67);

      // hold survives data changes
      step(1'b0, 1'b1, 1'b1, 1'b0, 4'd7);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd3);
      check("R6 hold ignores 3", 7'h07);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd12);
      check("R6 hold ignores 12", 7'h07);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);
      check("R6 hold ignores 0", 7'h07);

      // overrides leave the stored code alone
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'd1);
      check("R7 lamp test over held", 7'h7F);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd2);
      check("R7 release lamp test", 7'h07);
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'd4);
      check("R7 blank over held", 7'h00);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd5);
      check("R7 release blank", 7'h07);

      // one cycle latency: output unchanged before the edge
      step(1'b0, 1'b1, 1'b1, 1'b0, 4'd4);
      check("R8 new value after edge", 7'h66);
      @(negedge clk);
      bcd_in = 4'd1;
      #1;
      check("R8 no change before edge", 7'h66);
      @(posedge clk);
      #1;
      check("R8 change after edge", 7'h06);

      // reset clears the held code
      step(1'b0, 1'b1, 1'b1, 1'b0, 4'd5);
      step(1'b1, 1'b1, 1'b1, 1'b1, 4'd5);
      check("R9 reset darkens", 7'h00);
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd9);
      check("R9 held code cleared", 7'h3F);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule